// File: doc/BRIEF.md
# Lane-Structured Transmit Frame Encapsulator

This block sits between a user data source and a 64-bit, four-lane link stream. Each output word is two 32-bit beats: bits [63:32] go out first, bits [31:0] second. Each beat has four byte lanes, and lane 0 is the low byte of the beat. Each byte has its own control flag: `tx_ctrl[i]` belongs to byte `tx_data[8*i+7:8*i]`. A flag of 1 marks a control character and a flag of 0 marks a data byte.

After reset the block sends only idle words for a fixed synchronisation period. It then takes user frames over a ready/valid handshake. The user marks the final word of a frame with `in_last`. The block puts a header word before each frame and a trailer word after it. Between the trailer of one frame and the header of the next it sends a minimum number of idle words. The user sees `in_ready` high only while a frame body is open. Outside that window any word the user offers is held until the block takes it.

Top module: `xtx_frame_encap`

## Requirements
- R1: While reset (`rst_n` low) is applied, the output is the idle word (data 0x0707070707070707, control 0xFF) and `in_ready` is low.
- R2: After reset is released, exactly STARTUP_CYCLES idle words are sent and `in_ready` stays low. If a word is offered throughout, the first header follows at once.
- R3: Each frame opens with one header word: data 0x07070707FFFFFFFB, control 0xF1. This puts the start character 0xFB, flagged as control, in lane 0 of the second beat. The FF filler bytes are data bytes.
- R4: User words taken by handshake (`in_valid` and `in_ready` both high at a clock edge) appear one clock later, unchanged and in order, with control 0x00. A word offered while `in_ready` is low is not consumed.
- R5: The clock after the word marked `in_last` is sent, the trailer word goes out: data 0x070707FD07070707, control 0xFF. This puts the terminate character 0xFD in lane 0 of the first beat.
- R6: Exactly MIN_GAP_WORDS idle words separate a trailer from the next header when the next frame is already waiting. There are never fewer.
- R7: `in_ready` is high only while a frame body is open. It rises only in the clock after a header is issued and falls in the clock after the last word is taken.
- R8: If `in_valid` is low while `in_ready` is high, one idle word is sent inside the frame and no user word is lost.
- R9: A control-flagged 0xFB never appears in lanes 1 to 3 of either beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 64 | User data word |
| in_valid | input | 1 | User word present |
| in_last | input | 1 | Marks the final word of a frame |
| in_ready | output | 1 | Block takes the word at this edge |
| tx_data | output | 64 | Link word, two beats of four byte lanes |
| tx_ctrl | output | 8 | Per-byte control flags |

## Verification
Two events can fall in the same clock. The last idle word of the gap (or of the startup period) can go out in the same cycle as the decision to open the next frame. The trailer can also fall in the same cycle as a user word that is already waiting for the following frame. The bench provokes both cases by raising `in_valid` for the next frame as soon as the previous one is accepted, so the request is already pending while the gap counter runs out. The result is judged by counting idle words between each trailer and the next header, which must equal MIN_GAP_WORDS, and by checking that the held word still arrives in order after the header. Stalls inside a frame are counted and must match the idle words seen between header and trailer.

// File: rtl/xtx_pkg.sv
package xtx_pkg;

  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned BEAT_LANES = 4;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_FILL  = 8'hFF;

  typedef struct packed {
    logic [WORD_W-1:0]     d;
    logic [WORD_BYTES-1:0] c;
  } lword_t;

  typedef enum logic [1:0] {SEL_IDLE, SEL_HDR, SEL_TRL, SEL_DATA} wsel_t;

  typedef enum logic [2:0] {ST_SYNC, ST_OPEN, ST_BODY, ST_TAIL, ST_GAP} fstate_t;

  function automatic lword_t idle_word();
    lword_t w;
    for (int b = 0; b < int'(WORD_BYTES); b++) w.d[8*b +: 8] = CH_IDLE;
    w.c = '1;
    return w;
  endfunction

  // first beat idle, second beat start in lane 0 with filler data above it
  function automatic lword_t hdr_word();
    lword_t w;
    w.d = {{BEAT_LANES{CH_IDLE}}, {(BEAT_LANES-1){CH_FILL}}, CH_START};
    w.c = {{BEAT_LANES{1'b1}}, {(BEAT_LANES-1){1'b0}}, 1'b1};
    return w;
  endfunction

  // terminate in lane 0 of the first beat, idle elsewhere
  function automatic lword_t trl_word();
    lword_t w;
    w.d = {{(BEAT_LANES-1){CH_IDLE}}, CH_TERM, {BEAT_LANES{CH_IDLE}}};
    w.c = '1;
    return w;
  endfunction

  function automatic lword_t data_word(input logic [WORD_W-1:0] payload);
    lword_t w;
    w.d = payload;
    w.c = '0;
    return w;
  endfunction

  function automatic logic start_misplaced(input lword_t w);
    logic bad;
    bad = 1'b0;
    for (int b = 0; b < int'(WORD_BYTES); b++)
      if ((b % int'(BEAT_LANES)) != 0 && w.c[b] && w.d[8*b +: 8] == CH_START) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/xtx_span_counter.sv
module xtx_span_counter #(
  parameter int unsigned SPAN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned EFF = (SPAN < 1) ? 1 : SPAN;
  localparam int unsigned CW  = (EFF > 1) ? $clog2(EFF) : 1;
  localparam logic [CW-1:0] TOP = CW'(EFF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

  assign last = run && (cnt == TOP);
endmodule

// File: rtl/xtx_word_mux.sv
module xtx_word_mux
  import xtx_pkg::*;
(
  input  wsel_t              sel,
  input  logic [WORD_W-1:0]  payload,
  output lword_t             word
);
  always_comb begin
    case (sel)
      SEL_HDR:  word = hdr_word();
      SEL_TRL:  word = trl_word();
      SEL_DATA: word = data_word(payload);
      default:  word = idle_word();
    endcase
  end
endmodule

// File: rtl/xtx_frame_encap.sv
module xtx_frame_encap
  import xtx_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 156250,
  parameter int unsigned MIN_GAP_WORDS  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_ready,
  output logic [63:0] tx_data,
  output logic [7:0]  tx_ctrl
);
  fstate_t state, state_nx;
  wsel_t   sel;
  lword_t  word_nx, out_q;
  logic    sync_last, gap_last;

  // named events for the checker
  logic sync_busy, gap_busy, ev_open, ev_beat, ev_close, ev_stall;
  assign sync_busy = (state == ST_SYNC);
  assign gap_busy  = (state == ST_GAP);
  assign ev_open   = (state == ST_OPEN) && in_valid;
  assign ev_beat   = (state == ST_BODY) && in_valid;
  assign ev_close  = ev_beat && in_last;
  assign ev_stall  = (state == ST_BODY) && !in_valid;

  xtx_span_counter #(.SPAN(STARTUP_CYCLES)) sync_cnt_i (
    .clk(clk), .rst_n(rst_n), .run(sync_busy), .last(sync_last)
  );

  generate
    if (MIN_GAP_WORDS > 0) begin : g_gap
      xtx_span_counter #(.SPAN(MIN_GAP_WORDS)) gap_cnt_i (
        .clk(clk), .rst_n(rst_n), .run(gap_busy), .last(gap_last)
      );
    end else begin : g_nogap
      assign gap_last = gap_busy;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    sel      = SEL_IDLE;
    case (state)
      ST_SYNC: if (sync_last) state_nx = ST_OPEN;
      ST_OPEN: if (in_valid) begin
        sel      = SEL_HDR;
        state_nx = ST_BODY;
      end
      ST_BODY: begin
        if (in_valid) sel = SEL_DATA;
        if (ev_close) state_nx = ST_TAIL;
      end
      ST_TAIL: begin
        sel      = SEL_TRL;
        state_nx = (MIN_GAP_WORDS > 0) ? ST_GAP : ST_OPEN;
      end
      ST_GAP:  if (gap_last) state_nx = ST_OPEN;
      default: state_nx = ST_SYNC;
    endcase
  end

  xtx_word_mux mux_i (.sel(sel), .payload(in_data), .word(word_nx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_SYNC;
      out_q <= idle_word();
    end else begin
      state <= state_nx;
      out_q <= word_nx;
    end
  end

  assign in_ready = (state == ST_BODY);
  assign tx_data  = out_q.d;
  assign tx_ctrl  = out_q.c;
endmodule

// File: rtl/xtx_frame_encap_chk.sv
module xtx_frame_encap_chk
  import xtx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] in_data,
  input logic        in_ready,
  input logic [63:0] tx_data,
  input logic [7:0]  tx_ctrl,
  input logic        ev_open,
  input logic        ev_beat,
  input logic        ev_close,
  input logic        ev_stall,
  input logic        sync_busy,
  input logic        gap_busy
);
  localparam lword_t IW = idle_word();
  localparam lword_t HW = hdr_word();
  localparam lword_t TW = trl_word();

  lword_t cur;
  assign cur = '{d: tx_data, c: tx_ctrl};

  a_r2_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |=> (cur == IW));
  a_r2_sync_noready: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> !in_ready);
  a_r3_header: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |=> (cur == HW));
  a_r4_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat |=> (tx_data == $past(in_data) && tx_ctrl == 8'h00));
  a_r5_trailer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> ##1 (cur == TW));
  a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |=> (cur == IW));
  a_r7_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(ev_open));
  a_r7_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> !in_ready);
  a_r8_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> (cur == IW));
  a_r9_start_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    !start_misplaced(cur));
endmodule

bind xtx_frame_encap xtx_frame_encap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ready(in_ready),
  .tx_data(tx_data), .tx_ctrl(tx_ctrl), .ev_open(ev_open), .ev_beat(ev_beat),
  .ev_close(ev_close), .ev_stall(ev_stall), .sync_busy(sync_busy), .gap_busy(gap_busy)
);

// File: tb/xtx_frame_encap_tb_top.sv
module xtx_frame_encap_tb_top;
  localparam int STARTUP = 20;
  localparam int GAP     = 2;

  localparam logic [71:0] IDLE_W = {64'h0707070707070707, 8'hFF};
  localparam logic [71:0] HDR_W  = {64'h07070707FFFFFFFB, 8'hF1};
  localparam logic [71:0] TRL_W  = {64'h070707FD07070707, 8'hFF};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [63:0] tx_data;
  logic [7:0]  tx_ctrl;

  always #2.5 clk = ~clk;

  xtx_frame_encap #(.STARTUP_CYCLES(STARTUP), .MIN_GAP_WORDS(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  int n_run = 0, n_fail = 0;
  logic [71:0] expq[$];
  int stalls = 0, frames = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word_for(input int f, input int i);
    if (f == 1 && i == 0) return 64'h0707070707070707;
    if (f == 4 && i == 1) return 64'hFBFBFBFBFBFBFBFB;
    return {8'(f), 8'(i), 48'h5A5A_1234_C3C3} ^ {32'h0, 8'(i * 3), 24'h0};
  endfunction

  // driver: expected items go into the scoreboard queue
  task automatic send_frame(input int f, input int len, input int stall_every);
    expq.push_back(HDR_W);
    for (int i = 0; i < len; i++) begin
      if (stall_every != 0 && i != 0 && (i % stall_every) == 0) begin
        if (in_ready) stalls++;
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = word_for(f, i);
      in_last  = (i == len - 1);
      expq.push_back({word_for(f, i), 8'h00});
      while (1) begin
        bit take;
        take = in_ready;
        @(posedge clk);
        @(negedge clk);
        if (take) break;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    expq.push_back(TRL_W);
    frames++;
  endtask

  // monitor
  bit seen = 1'b0, in_frm = 1'b0;
  int pre_idle = 0, gap_idle = 0, frame_idle = 0, ready_pre = 0, misplaced = 0, hdrs = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic [71:0] w, e;
        w = {tx_data, tx_ctrl};
        if (w == IDLE_W) begin
          if (!seen) pre_idle++;
          else if (in_frm) frame_idle++;
          else gap_idle++;
        end else begin
          if (w == HDR_W) begin
            if (!seen) chk(pre_idle == STARTUP, "R2 startup idles", 72'(pre_idle), 72'(STARTUP));
            else chk(gap_idle == GAP, "R6 gap idles", 72'(gap_idle), 72'(GAP));
            seen = 1'b1; in_frm = 1'b1; hdrs++;
          end
          if (w == TRL_W) begin
            in_frm = 1'b0; gap_idle = 0;
          end
          for (int b = 0; b < 8; b++)
            if ((b % 4) != 0 && tx_ctrl[b] && tx_data[8*b +: 8] == 8'hFB) misplaced++;
          if (expq.size() == 0) chk(1'b0, "R4 unexpected word", w, 72'h0);
          else begin
            e = expq.pop_front();
            if (e == HDR_W)      chk(w == e, "R3 header", w, e);
            else if (e == TRL_W) chk(w == e, "R5 trailer", w, e);
            else                 chk(w == e, "R4 data", w, e);
          end
        end
        if (!seen && in_ready) ready_pre++;
        if (in_ready) chk(in_frm, "R7 ready outside frame", 72'(in_ready), 72'(in_frm));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({tx_data, tx_ctrl} == IDLE_W, "R1 reset word", {tx_data, tx_ctrl}, IDLE_W);
    chk(in_ready == 1'b0, "R1 reset ready", 72'(in_ready), 72'h0);
    rst_n = 1'b1;
    send_frame(0, 1, 0);
    send_frame(1, 3, 0);
    send_frame(2, 5, 2);
    send_frame(3, 2, 0);
    send_frame(4, 8, 3);
    send_frame(5, 4, 0);
    repeat (GAP + 6) @(negedge clk);
    chk(expq.size() == 0, "R4 queue drained", 72'(expq.size()), 72'h0);
    chk(hdrs == frames, "R3 header count", 72'(hdrs), 72'(frames));
    chk(ready_pre == 0, "R2 ready during sync", 72'(ready_pre), 72'h0);
    chk(frame_idle == stalls, "R8 in-frame idles", 72'(frame_idle), 72'(stalls));
    chk(misplaced == 0, "R9 start lane", 72'(misplaced), 72'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule